// File: doc/BRIEF.md
# Watermarked Sample Packet Buffer

This block sits between an acquisition channel and a shared data link. It groups a fixed number of incoming samples into a packet that carries a header (sequence number, priority bit, mode byte), the samples themselves, and a trailer (start-of-packet timestamp and a CRC-16). Packets are stored in a word FIFO and leave through a ready/valid output, one word per handshake, only once they are complete.

Occupancy is published as three watermark flags and a throttle output with hysteresis, so the source can slow down before storage runs out. Space is reserved for a whole packet when its first sample arrives. Under pressure, background packets are discarded first, while triggered-window (high-priority) packets are kept as long as a full packet still fits. Every discarded packet still consumes a sequence number, so the gap stays visible downstream. A drop counter with per-class sticky flags, link CRC-error and retry counters, and a peak-occupancy register can be read through a small status port and cleared by writing ones.

Top module: `pkt_stream_buffer`

## Requirements
- R1: After reset, out_valid, throttle and all three watermark flags are 0, and all four status registers read 0.
- R2: Each packet is SAMPLES+2 words of 32 bits: a header {seq[31:16], prio[15], zero[14:8], mode[7:0]}, the SAMPLES input words in arrival order, then a trailer {timestamp[31:16], crc[15:0]}. out_last is 1 only on the trailer word.
- R3: The sequence number starts at 0 after reset and increases by one for every packet started, accepted or dropped.
- R4: The trailer CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF, no reflection, MSB first, over the header word and then each sample word.
- R5: The trailer timestamp is a 16-bit free-running cycle count taken when the first sample is accepted, so two packets' timestamps differ by the number of cycles between their first samples.
- R6: wm_low, wm_mid and wm_high are 1 exactly when the reserved occupancy (in words) is at least LOW_WM, MID_WM and HIGH_WM respectively.
- R7: throttle sets on the edge after occupancy reaches MID_WM and clears only on the edge after occupancy falls below LOW_WM; between the two it holds.
- R8: A low-priority packet whose first sample arrives while occupancy is at or above HIGH_WM is dropped entirely; none of its words appear at the output.
- R9: A high-priority packet is accepted whenever DEPTH minus occupancy is at least SAMPLES+2, and dropped entirely otherwise.
- R10: Status address 0 reads {hi_flag[31], lo_flag[30], drop_count[CNT_W-1:0]}; each dropped packet adds one to the count and sets the sticky flag of its priority class.
- R11: Address 1 counts link_crc_err cycles and address 2 counts link_retry cycles; these counters and the drop count stop at 2^CNT_W-1.
- R12: Address 3 reads the highest occupancy seen since reset or since its last clear.
- R13: A status write clears, by stat_wdata bit: 0 the drop count and both flags, 1 the CRC counter, 2 the retry counter, 3 the peak (reloaded with the current occupancy). A clear wins over a same-cycle event.
- R14: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 32 | Sample word |
| in_prio | input | 1 | Priority tag, taken from the first sample of a packet |
| cfg_mode | input | 8 | Mode byte written into each header |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Output consumer accepts the word |
| out_data | output | 32 | Output word |
| out_last | output | 1 | Marks the trailer word |
| wm_low | output | 1 | Occupancy at or above LOW_WM |
| wm_mid | output | 1 | Occupancy at or above MID_WM |
| wm_high | output | 1 | Occupancy at or above HIGH_WM |
| throttle | output | 1 | Slow-down request to the source, with hysteresis |
| link_crc_err | input | 1 | Link CRC error event, one per cycle high |
| link_retry | input | 1 | Link retry event, one per cycle high |
| stat_addr | input | 2 | Status register select |
| stat_wr | input | 1 | Status clear strobe |
| stat_wdata | input | 4 | Write-one-to-clear mask |
| stat_rdata | output | 32 | Selected status register, combinational |

## Verification
Occupancy, and with it the watermark flags, rises on the edge that takes a packet's first sample. The throttle follows one edge later. A packet becomes visible at the output on the edge after its last sample. Status reads are combinational, while clears and counter updates land on the next edge. The bench drives on falling edges, lets every stimulus finish with at least one idle edge, and then samples on a later falling edge. Each watermark, throttle and status check therefore looks at values that are at least one full cycle old.

// File: rtl/pkt_pkg.sv
// Shared constants and the CRC-16 step used by the packet buffer.
// Assumes a 32-bit word; the header layout depends on that width.
package pkt_pkg;
    localparam int WORD_W = 32;

    // Folds one 32-bit word into a CRC-16 (poly 0x1021, MSB first).
    function automatic logic [15:0] crc16_word(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            fb = r[15] ^ w[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction
endpackage

// File: rtl/pkt_framer.sv
// Groups samples into packets, decides acceptance at the first sample,
// and produces the write traffic into the ring.
// Assumes SAMPLES >= 2 so header and trailer never share a cycle.
module pkt_framer
    import pkt_pkg::*;
#(
    parameter int SAMPLES = 14,
    parameter int DEPTH   = 64,
    parameter int HIGH_WM = 48,
    parameter int PTR_W   = 7,
    parameter int IDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_prio,
    input  logic [7:0]        mode,
    input  logic [15:0]       ts_now,
    input  logic [PTR_W-1:0]  level,
    input  logic [PTR_W-1:0]  alloc_ptr,
    output logic              a_we,
    output logic [PTR_W-1:0]  a_addr,
    output logic [WORD_W-1:0] a_data,
    output logic              b_we,
    output logic [PTR_W-1:0]  b_addr,
    output logic [WORD_W-1:0] b_data,
    output logic              accept,
    output logic              commit,
    output logic              drop
);
    localparam int PKT_W = SAMPLES + 2;

    logic [IDX_W-1:0]  idx_q;
    logic              active_q;
    logic [15:0]       seq_q, crc_q, ts_q;
    logic [PTR_W-1:0]  base_q, base_now, free_w;
    logic              first, ok, last;
    logic [WORD_W-1:0] hdr;
    logic [15:0]       crc_in, crc_nx;

    // Acceptance decision and CRC chain for the current sample.
    always_comb begin
        first    = in_valid && (idx_q == '0);
        free_w   = PTR_W'(DEPTH) - level;
        ok       = (free_w >= PTR_W'(PKT_W)) && (in_prio || (level < PTR_W'(HIGH_WM)));
        accept   = first && ok;
        drop     = first && !ok;
        last     = in_valid && active_q && (idx_q == IDX_W'(SAMPLES - 1));
        commit   = last;
        hdr      = {seq_q, in_prio, 7'b0, mode};
        crc_in   = first ? crc16_word(16'hFFFF, hdr) : crc_q;
        crc_nx   = crc16_word(crc_in, in_data);
        base_now = first ? alloc_ptr : base_q;
    end

    // Port A carries the header at acceptance and the trailer at the last sample.
    always_comb begin
        a_we   = accept || last;
        a_addr = accept ? alloc_ptr : (base_q + PTR_W'(SAMPLES + 1));
        a_data = accept ? hdr : {ts_q, crc_nx};
    end

    // Port B carries every sample of an accepted packet.
    always_comb begin
        b_we   = accept || (in_valid && active_q && (idx_q != '0));
        b_addr = base_now + PTR_W'(idx_q) + PTR_W'(1);
        b_data = in_data;
    end

    // Packet position, sequence, base address, timestamp and running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            active_q <= 1'b0;
            seq_q    <= '0;
            crc_q    <= '0;
            base_q   <= '0;
            ts_q     <= '0;
        end else if (in_valid) begin
            idx_q <= (idx_q == IDX_W'(SAMPLES - 1)) ? '0 : idx_q + 1'b1;
            crc_q <= crc_nx;
            if (first) begin
                seq_q    <= seq_q + 1'b1;
                active_q <= ok;
                base_q   <= alloc_ptr;
                ts_q     <= ts_now;
            end else if (last) begin
                active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pkt_ring.sv
// Word storage with reserve, commit and read pointers. Words become
// readable only after their packet is committed.
// Assumes DEPTH is a power of two and commits come in allocation order.
module pkt_ring
    import pkt_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PKT_W = 16,
    parameter int PTR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_we,
    input  logic [PTR_W-1:0]  a_addr,
    input  logic [WORD_W-1:0] a_data,
    input  logic              b_we,
    input  logic [PTR_W-1:0]  b_addr,
    input  logic [WORD_W-1:0] b_data,
    input  logic              alloc,
    input  logic              commit,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic [PTR_W-1:0]  alloc_ptr,
    output logic [PTR_W-1:0]  level
);
    localparam int AW = PTR_W - 1;
    localparam int CW = $clog2(PKT_W);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  commit_q, rd_q;
    logic [CW-1:0]     rd_word_q;
    logic              take;

    // Two independent write ports into storage.
    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr[AW-1:0]] <= a_data;
        if (b_we) mem[b_addr[AW-1:0]] <= b_data;
    end

    // Output view and occupancy.
    always_comb begin
        out_valid = (commit_q != rd_q);
        out_data  = mem[rd_q[AW-1:0]];
        out_last  = (rd_word_q == CW'(PKT_W - 1));
        level     = alloc_ptr - rd_q;
        take      = out_valid && out_ready;
    end

    // Pointer advance on reserve, commit and read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_ptr <= '0;
            commit_q  <= '0;
            rd_q      <= '0;
            rd_word_q <= '0;
        end else begin
            if (alloc)  alloc_ptr <= alloc_ptr + PTR_W'(PKT_W);
            if (commit) commit_q  <= commit_q + PTR_W'(PKT_W);
            if (take) begin
                rd_q      <= rd_q + 1'b1;
                rd_word_q <= out_last ? '0 : rd_word_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pkt_health.sv
// Watermark flags, hysteretic throttle, loss and link counters, peak
// occupancy and the status read/clear port.
// Assumes LOW_WM < MID_WM < HIGH_WM <= DEPTH and CNT_W <= 30.
module pkt_health #(
    parameter int LOW_WM  = 16,
    parameter int MID_WM  = 32,
    parameter int HIGH_WM = 48,
    parameter int PTR_W   = 7,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] level,
    input  logic             drop,
    input  logic             drop_prio,
    input  logic             link_crc_err,
    input  logic             link_retry,
    input  logic [1:0]       stat_addr,
    input  logic             stat_wr,
    input  logic [3:0]       stat_wdata,
    output logic             wm_low,
    output logic             wm_mid,
    output logic             wm_high,
    output logic             throttle,
    output logic [CNT_W-1:0] crc_cnt,
    output logic [31:0]      stat_rdata
);
    logic [CNT_W-1:0] drop_cnt, retry_cnt;
    logic             flag_lo, flag_hi;
    logic [PTR_W-1:0] peak_q;
    logic [3:0]       clr;

    // Threshold comparisons and clear mask.
    always_comb begin
        wm_low  = level >= PTR_W'(LOW_WM);
        wm_mid  = level >= PTR_W'(MID_WM);
        wm_high = level >= PTR_W'(HIGH_WM);
        clr     = stat_wr ? stat_wdata : 4'b0;
    end

    // Throttle sets at the middle mark and releases below the low mark.
    always_ff @(posedge clk) begin
        if (!rst_n)         throttle <= 1'b0;
        else if (wm_mid)    throttle <= 1'b1;
        else if (!wm_low)   throttle <= 1'b0;
    end

    // Saturating counters and sticky flags; clears take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt  <= '0;
            flag_lo   <= 1'b0;
            flag_hi   <= 1'b0;
            crc_cnt   <= '0;
            retry_cnt <= '0;
        end else begin
            if (clr[0]) begin
                drop_cnt <= '0;
                flag_lo  <= 1'b0;
                flag_hi  <= 1'b0;
            end else if (drop) begin
                if (drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
                if (drop_prio) flag_hi <= 1'b1;
                else           flag_lo <= 1'b1;
            end
            if (clr[1])                              crc_cnt   <= '0;
            else if (link_crc_err && crc_cnt != '1)  crc_cnt   <= crc_cnt + 1'b1;
            if (clr[2])                              retry_cnt <= '0;
            else if (link_retry && retry_cnt != '1)  retry_cnt <= retry_cnt + 1'b1;
        end
    end

    // Highest occupancy since reset or last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              peak_q <= '0;
        else if (clr[3])         peak_q <= level;
        else if (level > peak_q) peak_q <= level;
    end

    // Status read multiplexer.
    always_comb begin
        stat_rdata = '0;
        unique case (stat_addr)
            2'd0: begin
                stat_rdata[CNT_W-1:0] = drop_cnt;
                stat_rdata[30]        = flag_lo;
                stat_rdata[31]        = flag_hi;
            end
            2'd1:    stat_rdata[CNT_W-1:0] = crc_cnt;
            2'd2:    stat_rdata[CNT_W-1:0] = retry_cnt;
            default: stat_rdata[PTR_W-1:0] = peak_q;
        endcase
    end
endmodule

// File: rtl/pkt_stream_buffer.sv
// Top of the packet buffer: framer, storage ring and health logic.
// Assumes the source counts samples into packets from reset onward;
// throttle is advisory and loss is reported rather than prevented.
module pkt_stream_buffer #(
    parameter int SAMPLES = 14,
    parameter int DEPTH   = 64,
    parameter int LOW_WM  = 16,
    parameter int MID_WM  = 32,
    parameter int HIGH_WM = 48,
    parameter int CNT_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    input  logic        in_prio,
    input  logic [7:0]  cfg_mode,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_last,
    output logic        wm_low,
    output logic        wm_mid,
    output logic        wm_high,
    output logic        throttle,
    input  logic        link_crc_err,
    input  logic        link_retry,
    input  logic [1:0]  stat_addr,
    input  logic        stat_wr,
    input  logic [3:0]  stat_wdata,
    output logic [31:0] stat_rdata
);
    localparam int PKT_W = SAMPLES + 2;
    localparam int PTR_W = $clog2(DEPTH) + 1;
    localparam int IDX_W = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;

    logic [15:0]      ts_cnt;
    logic [PTR_W-1:0] level, alloc_ptr, a_addr, b_addr;
    logic [31:0]      a_data, b_data;
    logic             a_we, b_we, accept, commit, drop;
    logic [CNT_W-1:0] crc_cnt;

    // Free-running cycle count used as the packet timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_cnt <= '0;
        else        ts_cnt <= ts_cnt + 1'b1;
    end

    pkt_framer #(
        .SAMPLES(SAMPLES), .DEPTH(DEPTH), .HIGH_WM(HIGH_WM),
        .PTR_W(PTR_W), .IDX_W(IDX_W)
    ) u_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_prio(in_prio), .mode(cfg_mode), .ts_now(ts_cnt), .level(level),
        .alloc_ptr(alloc_ptr), .a_we(a_we), .a_addr(a_addr), .a_data(a_data),
        .b_we(b_we), .b_addr(b_addr), .b_data(b_data), .accept(accept),
        .commit(commit), .drop(drop)
    );

    pkt_ring #(.DEPTH(DEPTH), .PKT_W(PKT_W), .PTR_W(PTR_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .a_we(a_we), .a_addr(a_addr), .a_data(a_data),
        .b_we(b_we), .b_addr(b_addr), .b_data(b_data), .alloc(accept),
        .commit(commit), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .alloc_ptr(alloc_ptr),
        .level(level)
    );

    pkt_health #(
        .LOW_WM(LOW_WM), .MID_WM(MID_WM), .HIGH_WM(HIGH_WM),
        .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_health (
        .clk(clk), .rst_n(rst_n), .level(level), .drop(drop), .drop_prio(in_prio),
        .link_crc_err(link_crc_err), .link_retry(link_retry),
        .stat_addr(stat_addr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .wm_low(wm_low), .wm_mid(wm_mid), .wm_high(wm_high),
        .throttle(throttle), .crc_cnt(crc_cnt), .stat_rdata(stat_rdata)
    );
endmodule

// File: rtl/pkt_stream_chk.sv
// Temporal properties of the packet buffer, bound into the top module.
module pkt_stream_chk #(
    parameter int DEPTH   = 64,
    parameter int LOW_WM  = 16,
    parameter int MID_WM  = 32,
    parameter int HIGH_WM = 48,
    parameter int PTR_W   = 7,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input logic             throttle,
    input logic             wm_low,
    input logic             wm_mid,
    input logic             wm_high,
    input logic [PTR_W-1:0] level,
    input logic             accept,
    input logic             in_prio,
    input logic             stat_wr,
    input logic [3:0]       stat_wdata,
    input logic [CNT_W-1:0] crc_cnt
);
    // R14
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R7
    throttle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(throttle) |-> $past(level) >= PTR_W'(MID_WM));
    // R7
    throttle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle) |-> $past(level) < PTR_W'(LOW_WM));
    // R6
    wm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_high |-> wm_mid) and (wm_mid |-> wm_low));
    // R8
    low_prio_admit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !in_prio |-> level < PTR_W'(HIGH_WM));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PTR_W'(DEPTH));
    // R11
    crc_cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(stat_wr) && $past(stat_wdata[1])) |-> crc_cnt >= $past(crc_cnt));
endmodule

bind pkt_stream_buffer pkt_stream_chk #(
    .DEPTH(DEPTH), .LOW_WM(LOW_WM), .MID_WM(MID_WM), .HIGH_WM(HIGH_WM),
    .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .throttle(throttle), .wm_low(wm_low), .wm_mid(wm_mid),
    .wm_high(wm_high), .level(level), .accept(accept), .in_prio(in_prio),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .crc_cnt(crc_cnt)
);

// File: tb/pkt_stream_buffer_test.sv
// Directed bench: one task per scenario, each checking its own results.
module pkt_stream_buffer_test;
    localparam int SAMPLES = 4;
    localparam int PKT_W   = SAMPLES + 2;

    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, in_prio = 0, out_ready = 0;
    logic [31:0] in_data = 0;
    logic [7:0]  cfg_mode = 0;
    logic        link_crc_err = 0, link_retry = 0, stat_wr = 0;
    logic [1:0]  stat_addr = 0;
    logic [3:0]  stat_wdata = 0;
    logic        out_valid, out_last, wm_low, wm_mid, wm_high, throttle;
    logic [31:0] out_data, stat_rdata;

    int checks = 0, failures = 0, cyc = 0;
    int start_a, start_b;
    logic [15:0] ts_a, ts_b;

    pkt_stream_buffer #(.SAMPLES(SAMPLES), .DEPTH(32), .LOW_WM(8), .MID_WM(16),
                        .HIGH_WM(20), .CNT_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_prio(in_prio), .cfg_mode(cfg_mode), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .wm_low(wm_low), .wm_mid(wm_mid), .wm_high(wm_high), .throttle(throttle),
        .link_crc_err(link_crc_err), .link_retry(link_retry),
        .stat_addr(stat_addr), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    task automatic send_pkt(input logic prio, input logic [31:0] base, output int start);
        for (int i = 0; i < SAMPLES; i++) begin
            @(negedge clk);
            if (i == 0) start = cyc;
            in_valid = 1; in_prio = prio; in_data = base + 32'(i);
        end
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic read_pkt(input logic [15:0] seq, input logic prio, input logic [7:0] mode,
                            input logic [31:0] base, output logic [15:0] ts);
        logic [31:0] hdr, w;
        logic [15:0] c;
        hdr = {seq, prio, 7'b0, mode};
        c = ref_crc(16'hFFFF, hdr);
        @(negedge clk);
        out_ready = 1;
        for (int k = 0; k < PKT_W; k++) begin
            while (!out_valid) @(negedge clk);
            w = out_data;
            if (k == 0) check("R2/R3 header", w, hdr);
            else if (k <= SAMPLES) begin
                check("R2 sample", w, base + 32'(k - 1));
                c = ref_crc(c, base + 32'(k - 1));
            end else begin
                check("R4 crc", {16'h0, w[15:0]}, {16'h0, c});
                ts = w[31:16];
            end
            check("R2 out_last", {31'b0, out_last}, {31'b0, k == PKT_W - 1});
            @(negedge clk);
        end
        out_ready = 0;
    endtask

    task automatic read_stat(input logic [1:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        stat_addr = a;
        #1 check(req, stat_rdata, exp);
    endtask

    task automatic clear(input logic [3:0] mask);
        @(negedge clk);
        stat_wr = 1; stat_wdata = mask;
        @(negedge clk);
        stat_wr = 0; stat_wdata = 0;
    endtask

    task automatic t_reset();
        check("R1 out_valid", {31'b0, out_valid}, 0);
        check("R1 throttle", {31'b0, throttle}, 0);
        check("R1 watermarks", {29'b0, wm_low, wm_mid, wm_high}, 0);
        for (int a = 0; a < 4; a++) read_stat(2'(a), "R1 status", 0);
    endtask

    task automatic t_basic();
        cfg_mode = 8'h5A;
        send_pkt(0, 32'h1000, start_a);
        send_pkt(1, 32'h2000, start_b);
        read_pkt(16'd0, 0, 8'h5A, 32'h1000, ts_a);
        read_pkt(16'd1, 1, 8'h5A, 32'h2000, ts_b);
        check("R5 timestamp delta", {16'h0, ts_b - ts_a}, {16'h0, 16'(start_b - start_a)});
        check("R2 drained", {31'b0, out_valid}, 0);
    endtask

    task automatic t_pressure();
        int s;
        logic [15:0] t;
        cfg_mode = 8'hC3;
        send_pkt(0, 32'h3000, s);   // level 6
        check("R6 wm at 6", {29'b0, wm_low, wm_mid, wm_high}, 3'b000);
        send_pkt(0, 32'h3100, s);   // level 12
        check("R6 wm at 12", {29'b0, wm_low, wm_mid, wm_high}, 3'b100);
        check("R7 throttle below mid", {31'b0, throttle}, 0);
        send_pkt(0, 32'h3200, s);   // level 18
        check("R6 wm at 18", {29'b0, wm_low, wm_mid, wm_high}, 3'b110);
        check("R7 throttle at mid", {31'b0, throttle}, 1);
        send_pkt(0, 32'h3300, s);   // level 24
        check("R6 wm at 24", {29'b0, wm_low, wm_mid, wm_high}, 3'b111);
        send_pkt(0, 32'h3400, s);   // seq 6 dropped, low class
        read_stat(0, "R8 low drop counted", 32'h4000_0001);
        send_pkt(1, 32'h3500, s);   // seq 7 accepted, level 30
        send_pkt(1, 32'h3600, s);   // seq 8 dropped, no room
        read_stat(0, "R9/R10 drop flags and count", 32'hC000_0002);
        read_stat(3, "R12 peak", 32'd30);
        read_pkt(16'd2, 0, 8'hC3, 32'h3000, t);
        read_pkt(16'd3, 0, 8'hC3, 32'h3100, t);
        read_pkt(16'd4, 0, 8'hC3, 32'h3200, t);
        repeat (2) @(negedge clk);
        check("R7 throttle held between marks", {31'b0, throttle}, 1);
        check("R6 wm at 12 draining", {29'b0, wm_low, wm_mid, wm_high}, 3'b100);
        read_pkt(16'd5, 0, 8'hC3, 32'h3300, t);
        repeat (2) @(negedge clk);
        check("R7 throttle released below low", {31'b0, throttle}, 0);
        read_pkt(16'd7, 1, 8'hC3, 32'h3500, t);
        repeat (2) @(negedge clk);
        check("R8/R9 dropped packets absent", {31'b0, out_valid}, 0);
    endtask

    task automatic t_counters();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); link_crc_err = 1;
            @(negedge clk); link_crc_err = 0;
        end
        @(negedge clk); link_retry = 1;
        repeat (20) @(negedge clk);
        link_retry = 0;
        read_stat(1, "R11 crc count", 32'd3);
        read_stat(2, "R11 retry saturates", 32'd15);
        clear(4'b0010);
        read_stat(1, "R13 crc cleared", 32'd0);
        read_stat(2, "R13 retry untouched", 32'd15);
        clear(4'b1101);
        read_stat(0, "R13 drops cleared", 32'd0);
        read_stat(2, "R13 retry cleared", 32'd0);
        read_stat(3, "R13 peak reloaded", 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_pressure();
        t_counters();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule